// File: doc/BRIEF.md
# External Memory Access Sequencer

This block produces the pin-level timing for one access at a time to an external memory divided into three segments, over a 16-bit data bus. A request gives the segment, the direction and the write data. The block then drives the active-low read/write strobe, one active-high enable per segment, the data-bus output enable and the write data. It runs on a timing clock that is twice the instruction clock, which lets it place each pin edge with half-instruction-cycle resolution. All delays below are counted in timing-clock ticks. Tick 1 is the first timing-clock edge after the edge that accepts the request.

Three configuration inputs shape each access. The first sets how early the strobe falls on a write. The second sets whether write data reaches the bus half a cycle or a full cycle after the strobe falls. The third is a vector with one bit per segment that holds back that segment's enable by one tick. When write data is delayed, the whole bus-active window moves later and keeps its length. Its turn-off therefore moves later by the same amount. A segment that is read straight after a write can set its enable-delay bit so that its enable stays clear of the write driver.

Top module: `ext_mem_seq`

## Requirements
- R1: After reset, busy is 0, strobe_n is 1, every seg_en bit is 0, bus_oe is 0 and bus_wdata is 0.
- R2: A request is accepted on a rising edge where req_valid is 1, busy is 0 and req_seg is below 3. busy is then 1 from tick 1 until the tick on which the access ends, and 0 from that tick on. A request with req_seg equal to 3 is ignored, and busy stays 0.
- R3: For a write, strobe_n falls at tick S and rises at the end tick E. S is 1 when cfg_strobe_adv is 1 and 2 when it is 0.
- R4: For a write, bus_oe rises at tick S+1 when cfg_wdata_dly is 0 and at tick S+2 when it is 1. bus_oe is only ever high while strobe_n is low.
- R5: For a write, bus_oe stays high for exactly 2 ticks. The end tick E is the tick on which bus_oe falls, so E = S+3 without data delay and E = S+4 with it. strobe_n, the segment enable and busy all end on that same tick.
- R6: Only the enable of the requested segment (bit req_seg of seg_en) is ever driven. It rises at the access start tick, or one tick later when bit req_seg of cfg_seg_dly is 1. At most one enable is high at any time.
- R7: For a read, strobe_n stays 1 and bus_oe stays 0. The segment enable is high from tick 1 (tick 2 if delayed) up to tick 4, and busy is 1 for ticks 1 to 3.
- R8: The request fields and all configuration inputs are captured at acceptance. Changing them during an access does not change its timing. bus_wdata holds the accepted data for as long as bus_oe is high.
- R9: When a read follows a write back to back, no segment enable of the read is high while bus_oe is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk2x | input | 1 | Timing clock, twice the instruction clock and phase-aligned to it |
| rst | input | 1 | Synchronous active-high reset |
| cfg_strobe_adv | input | 1 | 1: the write strobe falls one tick earlier |
| cfg_wdata_dly | input | 1 | 1: write data goes onto the bus a full instruction cycle after the strobe falls |
| cfg_seg_dly | input | 3 | Per-segment enable delay of one tick |
| req_valid | input | 1 | Access request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_seg | input | 2 | Target segment, 0 to 2 |
| req_wdata | input | 16 | Write data |
| busy | output | 1 | An access is in progress |
| strobe_n | output | 1 | Read/write strobe, low during a write |
| seg_en | output | 3 | Per-segment memory enable, active high |
| bus_oe | output | 1 | Data-bus output enable |
| bus_wdata | output | 16 | Data driven onto the bus |

## Verification
All pins are registered from one tick counter and one captured access record. A wrong counter value or a wrong record field therefore shows up at the ports on the very next tick. It appears as a strobe, enable or output-enable edge one tick early or late, or on the wrong segment. The bench compares every pin on every tick of each access against a timeline computed from S and the delay bits. An early or late edge is caught within one instruction cycle. A window with the wrong length shows up as a busy that ends out of step with bus_oe. A mix-up between read and write shows up as bus_oe or strobe activity during a read.

// File: rtl/emts_pkg.sv
package emts_pkg;

    localparam int NUM_SEG = 3;
    localparam int SEG_W   = $clog2(NUM_SEG + 1);
    localparam int TICK_W  = 3;

    localparam logic [TICK_W-1:0] READ_END_TICK = TICK_W'(4);
    localparam logic [TICK_W-1:0] OE_LEN        = TICK_W'(2);

    // captured description of the access in flight
    typedef struct packed {
        logic             write;
        logic [SEG_W-1:0] seg;
        logic             adv;
        logic             wdly;
        logic             seg_dly;
    } acc_t;

    // tick numbers at which each pin turns on, and the common end tick
    typedef struct packed {
        logic [TICK_W-1:0] strobe_on;
        logic [TICK_W-1:0] oe_on;
        logic [TICK_W-1:0] en_on;
        logic [TICK_W-1:0] end_t;
    } win_t;

    function automatic logic [TICK_W-1:0] start_tick(acc_t a);
        return (a.write && !a.adv) ? TICK_W'(2) : TICK_W'(1);
    endfunction

    function automatic logic [TICK_W-1:0] oe_tick(acc_t a);
        return start_tick(a) + (a.wdly ? TICK_W'(2) : TICK_W'(1));
    endfunction

    function automatic logic [TICK_W-1:0] end_tick(acc_t a);
        return a.write ? (oe_tick(a) + OE_LEN) : READ_END_TICK;
    endfunction

    function automatic logic [TICK_W-1:0] en_tick(acc_t a);
        return start_tick(a) + TICK_W'(a.seg_dly);
    endfunction

endpackage

// File: rtl/emts_window.sv
module emts_window
    import emts_pkg::*;
(
    input  acc_t acc,
    output win_t win
);
    always_comb begin
        win.strobe_on = start_tick(acc);
        win.oe_on     = oe_tick(acc);
        win.en_on     = en_tick(acc);
        win.end_t     = end_tick(acc);
    end
endmodule

// File: rtl/emts_ctrl.sv
module emts_ctrl
    import emts_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic              clk2x,
    input  logic              rst,
    input  logic              cfg_strobe_adv,
    input  logic              cfg_wdata_dly,
    input  logic [NUM_SEG-1:0] cfg_seg_dly,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [SEG_W-1:0]  req_seg,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              n_active,
    output logic [TICK_W-1:0] n_tick,
    output acc_t              n_acc,
    output logic [DATA_W-1:0] n_data
);
    logic              active_q;
    logic [TICK_W-1:0] tick_q;
    acc_t              acc_q;
    logic [DATA_W-1:0] data_q;
    logic              accept;
    logic              last;
    logic              sel_dly;

    always_comb begin
        sel_dly = 1'b0;
        for (int i = 0; i < NUM_SEG; i++) begin
            if (req_seg == SEG_W'(i)) sel_dly = cfg_seg_dly[i];
        end
    end

    assign accept = !active_q && req_valid && (req_seg < SEG_W'(NUM_SEG));
    assign last   = active_q && (tick_q == end_tick(acc_q) - TICK_W'(1));

    always_comb begin
        n_active = active_q;
        n_tick   = tick_q;
        n_acc    = acc_q;
        n_data   = data_q;
        if (accept) begin
            n_active      = 1'b1;
            n_tick        = TICK_W'(1);
            n_acc.write   = req_write;
            n_acc.seg     = req_seg;
            n_acc.adv     = cfg_strobe_adv;
            n_acc.wdly    = cfg_wdata_dly;
            n_acc.seg_dly = sel_dly;
            n_data        = req_wdata;
        end else if (last) begin
            n_active = 1'b0;
            n_tick   = '0;
        end else if (active_q) begin
            n_tick = tick_q + TICK_W'(1);
        end
    end

    always_ff @(posedge clk2x) begin
        if (rst) begin
            active_q <= 1'b0;
            tick_q   <= '0;
            acc_q    <= '0;
            data_q   <= '0;
        end else begin
            active_q <= n_active;
            tick_q   <= n_tick;
            acc_q    <= n_acc;
            data_q   <= n_data;
        end
    end

    // captured access must not change while it runs
    assert_acc_held_R8: assert property (@(posedge clk2x) disable iff (rst)
        (active_q && !last) |=> $stable(acc_q));

    // the access always reaches its end tick within the counter range
    assert_tick_progress_R5: assert property (@(posedge clk2x) disable iff (rst)
        (active_q && !last) |=> (tick_q == $past(tick_q) + TICK_W'(1)));
endmodule

// File: rtl/emts_pins.sv
module emts_pins
    import emts_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic              clk2x,
    input  logic              rst,
    input  logic              n_active,
    input  logic [TICK_W-1:0] n_tick,
    input  acc_t              n_acc,
    input  logic [DATA_W-1:0] n_data,
    output logic              busy,
    output logic              strobe_n,
    output logic [NUM_SEG-1:0] seg_en,
    output logic              bus_oe,
    output logic [DATA_W-1:0] bus_wdata
);
    win_t               win;
    logic               in_win;
    logic               strobe_d;
    logic               oe_d;
    logic [NUM_SEG-1:0] en_d;

    emts_window u_win (
        .acc (n_acc),
        .win (win)
    );

    assign in_win   = n_active && (n_tick < win.end_t);
    assign strobe_d = in_win && n_acc.write && (n_tick >= win.strobe_on);
    assign oe_d     = in_win && n_acc.write && (n_tick >= win.oe_on);

    for (genvar i = 0; i < NUM_SEG; i++) begin : g_en
        assign en_d[i] = in_win && (n_acc.seg == SEG_W'(i)) && (n_tick >= win.en_on);
    end

    always_ff @(posedge clk2x) begin
        if (rst) begin
            busy      <= 1'b0;
            strobe_n  <= 1'b1;
            seg_en    <= '0;
            bus_oe    <= 1'b0;
            bus_wdata <= '0;
        end else begin
            busy      <= n_active;
            strobe_n  <= !strobe_d;
            seg_en    <= en_d;
            bus_oe    <= oe_d;
            bus_wdata <= n_data;
        end
    end

    assert_oe_under_strobe_R4: assert property (@(posedge clk2x) disable iff (rst)
        bus_oe |-> !strobe_n);

    assert_oe_two_ticks_R5: assert property (@(posedge clk2x) disable iff (rst)
        $rose(bus_oe) |=> bus_oe);

    assert_oe_not_three_R5: assert property (@(posedge clk2x) disable iff (rst)
        (bus_oe && $past(bus_oe)) |=> !bus_oe);

    assert_single_enable_R6: assert property (@(posedge clk2x) disable iff (rst)
        $onehot0(seg_en));

    assert_pins_need_busy_R2: assert property (@(posedge clk2x) disable iff (rst)
        ((|seg_en) || bus_oe || !strobe_n) |-> busy);

    assert_wdata_held_R8: assert property (@(posedge clk2x) disable iff (rst)
        (bus_oe && $past(bus_oe)) |-> $stable(bus_wdata));

    assert_no_read_overlap_R9: assert property (@(posedge clk2x) disable iff (rst)
        ((|seg_en) && strobe_n) |-> !bus_oe);
endmodule

// File: rtl/ext_mem_seq.sv
module ext_mem_seq
    import emts_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic              clk2x,
    input  logic              rst,
    input  logic              cfg_strobe_adv,
    input  logic              cfg_wdata_dly,
    input  logic [NUM_SEG-1:0] cfg_seg_dly,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [SEG_W-1:0]  req_seg,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              busy,
    output logic              strobe_n,
    output logic [NUM_SEG-1:0] seg_en,
    output logic              bus_oe,
    output logic [DATA_W-1:0] bus_wdata
);
    logic              n_active;
    logic [TICK_W-1:0] n_tick;
    acc_t              n_acc;
    logic [DATA_W-1:0] n_data;

    emts_ctrl #(.DATA_W(DATA_W)) u_ctrl (
        .clk2x          (clk2x),
        .rst            (rst),
        .cfg_strobe_adv (cfg_strobe_adv),
        .cfg_wdata_dly  (cfg_wdata_dly),
        .cfg_seg_dly    (cfg_seg_dly),
        .req_valid      (req_valid),
        .req_write      (req_write),
        .req_seg        (req_seg),
        .req_wdata      (req_wdata),
        .n_active       (n_active),
        .n_tick         (n_tick),
        .n_acc          (n_acc),
        .n_data         (n_data)
    );

    emts_pins #(.DATA_W(DATA_W)) u_pins (
        .clk2x     (clk2x),
        .rst       (rst),
        .n_active  (n_active),
        .n_tick    (n_tick),
        .n_acc     (n_acc),
        .n_data    (n_data),
        .busy      (busy),
        .strobe_n  (strobe_n),
        .seg_en    (seg_en),
        .bus_oe    (bus_oe),
        .bus_wdata (bus_wdata)
    );
endmodule

// File: tb/tb_ext_mem_seq.sv
module tb_ext_mem_seq;
    logic        clk2x = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_strobe_adv = 1'b0;
    logic        cfg_wdata_dly = 1'b0;
    logic [2:0]  cfg_seg_dly = 3'b000;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [1:0]  req_seg = 2'd0;
    logic [15:0] req_wdata = 16'h0;
    logic        busy, strobe_n, bus_oe;
    logic [2:0]  seg_en;
    logic [15:0] bus_wdata;

    int n_checks = 0;
    int n_fail = 0;
    bit finished = 0;

    always #10 clk2x = ~clk2x;

    ext_mem_seq dut (
        .clk2x(clk2x), .rst(rst),
        .cfg_strobe_adv(cfg_strobe_adv), .cfg_wdata_dly(cfg_wdata_dly),
        .cfg_seg_dly(cfg_seg_dly), .req_valid(req_valid), .req_write(req_write),
        .req_seg(req_seg), .req_wdata(req_wdata), .busy(busy), .strobe_n(strobe_n),
        .seg_en(seg_en), .bus_oe(bus_oe), .bus_wdata(bus_wdata)
    );

    // packed view of the pins: {busy, strobe_n, seg_en[2:0], bus_oe}
    function automatic logic [5:0] pins_now();
        return {busy, strobe_n, seg_en, bus_oe};
    endfunction

    function automatic logic [5:0] expect_pins(bit wr, int seg, bit adv, bit wdly,
                                               bit sd, int t);
        int s, e, oe_on;
        logic [5:0] v;
        s     = (wr && !adv) ? 2 : 1;
        oe_on = s + (wdly ? 2 : 1);
        e     = wr ? oe_on + 2 : 4;
        v[5]  = (t >= 1 && t < e);
        v[4]  = !(wr && t >= s && t < e);
        v[3:1] = (t >= s + int'(sd) && t < e) ? (3'b001 << seg) : 3'b000;
        v[0]  = wr && t >= oe_on && t < e;
        return v;
    endfunction

    task automatic check(string req, string what, logic [31:0] got, logic [31:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
        end
    endtask

    // R1
    task automatic test_reset();
        check("R1", "pins after reset", 32'(pins_now()), 32'(6'b010000));
        check("R1", "bus_wdata after reset", 32'(bus_wdata), 32'h0);
    endtask

    // runs one access and checks every pin on ticks 1..7 (R2 R3 R4 R5 R6 R7 R8)
    task automatic run_access(string req, bit wr, int seg, bit adv, bit wdly,
                              logic [2:0] sdv, logic [15:0] data, bit flip_cfg);
        @(negedge clk2x);
        cfg_strobe_adv = adv;
        cfg_wdata_dly  = wdly;
        cfg_seg_dly    = sdv;
        req_valid      = 1'b1;
        req_write      = wr;
        req_seg        = 2'(seg);
        req_wdata      = data;
        @(posedge clk2x);
        for (int k = 1; k <= 7; k++) begin
            @(negedge clk2x);
            check(req, $sformatf("pins tick %0d", k), 32'(pins_now()),
                  32'(expect_pins(wr, seg, adv, wdly, sdv[seg], k)));
            if (bus_oe) check(req, $sformatf("bus_wdata tick %0d", k), 32'(bus_wdata), 32'(data));
            if (k == 1) begin
                req_valid = 1'b0;
                if (flip_cfg) begin
                    cfg_strobe_adv = !adv;
                    cfg_wdata_dly  = !wdly;
                    cfg_seg_dly    = ~sdv;
                    req_seg        = 2'((seg + 1) % 3);
                    req_write      = !wr;
                    req_wdata      = ~data;
                end
            end
        end
    endtask

    // R2: segment 3 is not a valid target and is ignored
    task automatic test_bad_seg();
        @(negedge clk2x);
        req_valid = 1'b1;
        req_write = 1'b1;
        req_seg   = 2'd3;
        for (int k = 1; k <= 4; k++) begin
            @(negedge clk2x);
            check("R2", $sformatf("segment 3 ignored tick %0d", k), 32'(pins_now()),
                  32'(6'b010000));
        end
        req_valid = 1'b0;
    endtask

    // R9: write then read on the same segment, back to back
    task automatic test_back_to_back();
        int overlap = 0;
        int read_en_ticks = 0;
        bit read_issued = 0;
        bit read_accepted = 0;
        @(negedge clk2x);
        cfg_strobe_adv = 1'b1;
        cfg_wdata_dly  = 1'b1;
        cfg_seg_dly    = 3'b010;
        req_valid = 1'b1;
        req_write = 1'b1;
        req_seg   = 2'd1;
        req_wdata = 16'hBEEF;
        @(posedge clk2x);
        for (int k = 1; k <= 14; k++) begin
            @(negedge clk2x);
            if (k == 1) req_valid = 1'b0;
            if (bus_oe && (|seg_en) && strobe_n) overlap++;
            if (read_accepted && (|seg_en) && strobe_n) read_en_ticks++;
            if (read_issued && !read_accepted) begin
                read_accepted = 1'b1;
                req_valid = 1'b0;
            end
            if (k > 1 && !busy && !read_issued) begin
                read_issued = 1'b1;
                req_valid = 1'b1;
                req_write = 1'b0;
                req_seg   = 2'd1;
            end
        end
        check("R9", "read enable overlapping write drive", 32'(overlap), 32'd0);
        check("R9", "delayed read enable ticks", 32'(read_en_ticks), 32'd2);
    endtask

    initial begin
        repeat (3) @(posedge clk2x);
        @(negedge clk2x);
        rst = 1'b0;
        test_reset();
        // R3 R4 R5 R6: the four strobe/data delay combinations
        run_access("R3/R4/R5", 1'b1, 0, 1'b1, 1'b0, 3'b000, 16'h1234, 1'b0);
        run_access("R3/R4/R5", 1'b1, 1, 1'b0, 1'b0, 3'b000, 16'hA5A5, 1'b0);
        run_access("R3/R4/R5", 1'b1, 2, 1'b1, 1'b1, 3'b000, 16'h0F0F, 1'b0);
        run_access("R3/R4/R5", 1'b1, 0, 1'b0, 1'b1, 3'b000, 16'hFFFF, 1'b0);
        // R6: delayed segment enables, and a delay bit on another segment
        run_access("R6", 1'b1, 2, 1'b0, 1'b1, 3'b100, 16'h5555, 1'b0);
        run_access("R6", 1'b1, 1, 1'b1, 1'b0, 3'b101, 16'h00FF, 1'b0);
        // R7: reads with and without enable delay
        run_access("R7", 1'b0, 0, 1'b1, 1'b1, 3'b000, 16'h1111, 1'b0);
        run_access("R7", 1'b0, 2, 1'b0, 1'b0, 3'b100, 16'h2222, 1'b0);
        // R8: inputs changed right after acceptance
        run_access("R8", 1'b1, 1, 1'b0, 1'b1, 3'b010, 16'hC3C3, 1'b1);
        run_access("R8", 1'b0, 0, 1'b1, 1'b0, 3'b000, 16'h7E7E, 1'b1);
        test_bad_seg();
        test_back_to_back();
        finished = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk2x);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end
endmodule